// File: doc/BRIEF.md
# Load/Store Queue Occupancy Checker

This block keeps a running count of occupied entries in a load queue and a store queue. At dispatch it decides whether each offered instruction can be admitted. A dispatch request comes with two flags: one says the instruction reads memory and the other says it writes memory. A load barrier is offered with the read flag set, and a store barrier with the write flag set. Each barrier takes an entry exactly like an ordinary access.

The status answer is combinational. It is computed from the current counts and the request flags. An admitted request claims its entries at the next clock edge. Each load keeps its entry until it retires, which the pipeline signals with a one-cycle pulse on `ld_retire`. Each store keeps its entry until it commits, which is signalled by a pulse on `st_commit`.

Each queue's capacity is set by a parameter. A capacity of zero removes the limit for that queue. In that case its count saturates at the largest value the count width can hold.

Top module: `lsq_occupancy`

## Requirements
- R1: A queue whose capacity parameter is zero never raises its full flag and never causes a load-full (1) or store-full (2) status for itself.
- R2: For a queue with nonzero capacity, the full flag is high exactly when its used count equals the capacity. Each queue's empty flag is high exactly when its used count is zero.
- R3: `adm_status` is combinational in the same cycle as the request and is encoded as follows:
  - 0: the request can be admitted.
  - 1: the load queue is full.
  - 2: the store queue is full.
  - The value 3 never appears.
- R4: A request with both `dsp_rd` and `dsp_wr` low always yields status 0 and changes no count.
- R5: When `dsp_valid` is high and status is 0, each set flag adds exactly one to its queue's count at the next edge. Read-only requests, including load barriers, add to the load count. Write-only requests, including store barriers, add to the store count.
- R6: A request that both reads and writes needs a free entry in each queue. If both queues are full, status is 1. If only the store queue is full, status is 2. When admitted, it increments both counts.
- R7: Each `ld_retire` pulse lowers the load count by one at the next edge, and each `st_commit` pulse lowers the store count by one.
- R8: If an admitted request and a release hit the same queue in the same cycle, that queue's count stays unchanged.
- R9: A release while its queue's count is zero raises that queue's underflow output in the same cycle. The count stays at zero.
- R10: A request refused with status 1 or 2 changes neither count.
- R11: An unbounded queue's count stops at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsp_valid | input | 1 | Dispatch request present |
| dsp_rd | input | 1 | Request reads memory (load or load barrier) |
| dsp_wr | input | 1 | Request writes memory (store or store barrier) |
| ld_retire | input | 1 | One load entry is released |
| st_commit | input | 1 | One store entry is released |
| adm_status | output | 2 | 0 admit, 1 load queue full, 2 store queue full |
| lq_empty | output | 1 | Load queue has no used entries |
| lq_full | output | 1 | Load queue at capacity |
| sq_empty | output | 1 | Store queue has no used entries |
| sq_full | output | 1 | Store queue at capacity |
| lq_used | output | CNT_W | Used load entries |
| sq_used | output | CNT_W | Used store entries |
| lq_underflow | output | 1 | Load release seen at count zero |
| sq_underflow | output | 1 | Store release seen at count zero |

## Verification
The outputs fall into two groups by timing:
- Due in the same cycle as the inputs: `adm_status` and the two underflow outputs.
- Due one edge after the stimulus: the used counts, and the full and empty flags derived from them.

The bench drives stimulus just after the falling edge. It checks the count-derived outputs before changing the inputs, and checks the combinational answers one nanosecond after driving. Its model counts then advance, mirroring the rising edge in between. A second instance with an unbounded load queue sees the same stimulus and is driven into saturation.

// File: rtl/lsq_pkg.sv
// Shared types for the load/store queue occupancy checker.
package lsq_pkg;
    typedef enum logic [1:0] {
        ADM_OK      = 2'd0,
        ADM_LQ_FULL = 2'd1,
        ADM_SQ_FULL = 2'd2
    } adm_status_t;
endpackage

// File: rtl/lsq_slot_counter.sv
// Occupancy counter for one queue.
// Assumes: at most one allocate and one release per cycle, and CAP < 2**CNT_W.
// CAP == 0 selects an unbounded queue whose count saturates at all-ones.
module lsq_slot_counter #(
    parameter int CAP   = 4,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             rel,
    output logic [CNT_W-1:0] used,
    output logic             empty,
    output logic             full,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

    logic [CNT_W-1:0] used_nxt;

    // Next count: net change of allocate and release, clamped at both ends.
    always_comb begin
        used_nxt = used;
        if (alloc && !rel && used != MAX_V)
            used_nxt = used + 1'b1;
        else if (rel && !alloc && used != '0)
            used_nxt = used - 1'b1;
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) used <= '0;
        else        used <= used_nxt;
    end

    assign empty     = (used == '0);
    assign underflow = rel && (used == '0);

    // Full flag: absent for an unbounded queue.
    generate
        if (CAP == 0) begin : g_unbounded
            assign full = 1'b0;
        end else begin : g_bounded
            assign full = (used == CAP_V);
        end
    endgenerate
endmodule

// File: rtl/lsq_admit.sv
// Admission decision for one dispatch request.
// Assumes the full flags describe the current cycle. A load-queue shortage
// takes priority over a store-queue shortage.
module lsq_admit
    import lsq_pkg::*;
(
    input  logic        want_ld,
    input  logic        want_st,
    input  logic        lq_full,
    input  logic        sq_full,
    output adm_status_t status
);
    // Pick the status code; a request needing no entry is always admitted.
    always_comb begin
        if (want_ld && lq_full)      status = ADM_LQ_FULL;
        else if (want_st && sq_full) status = ADM_SQ_FULL;
        else                         status = ADM_OK;
    end
endmodule

// File: rtl/lsq_occupancy.sv
// Load/store queue occupancy checker: admits dispatch requests against
// per-queue capacities and tracks releases from retirement and commit.
// Assumes barriers are offered with the read or write flag like plain accesses.
module lsq_occupancy
    import lsq_pkg::*;
#(
    parameter int LQ_CAP = 4,
    parameter int SQ_CAP = 3,
    parameter int CNT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dsp_valid,
    input  logic             dsp_rd,
    input  logic             dsp_wr,
    input  logic             ld_retire,
    input  logic             st_commit,
    output logic [1:0]       adm_status,
    output logic             lq_empty,
    output logic             lq_full,
    output logic             sq_empty,
    output logic             sq_full,
    output logic [CNT_W-1:0] lq_used,
    output logic [CNT_W-1:0] sq_used,
    output logic             lq_underflow,
    output logic             sq_underflow
);
    adm_status_t status;
    logic        accept;

    lsq_admit u_admit (
        .want_ld (dsp_rd),
        .want_st (dsp_wr),
        .lq_full (lq_full),
        .sq_full (sq_full),
        .status  (status)
    );

    // Acceptance: a valid request whose status is admit.
    assign accept     = dsp_valid && (status == ADM_OK);
    assign adm_status = status;

    lsq_slot_counter #(.CAP(LQ_CAP), .CNT_W(CNT_W)) u_lq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (accept && dsp_rd),
        .rel       (ld_retire),
        .used      (lq_used),
        .empty     (lq_empty),
        .full      (lq_full),
        .underflow (lq_underflow)
    );

    lsq_slot_counter #(.CAP(SQ_CAP), .CNT_W(CNT_W)) u_sq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (accept && dsp_wr),
        .rel       (st_commit),
        .used      (sq_used),
        .empty     (sq_empty),
        .full      (sq_full),
        .underflow (sq_underflow)
    );
endmodule

// File: rtl/lsq_occupancy_chk.sv
// Property checker for lsq_occupancy, attached with bind.
module lsq_occupancy_chk #(
    parameter int LQ_CAP = 4,
    parameter int SQ_CAP = 3,
    parameter int CNT_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dsp_valid,
    input logic             dsp_rd,
    input logic             dsp_wr,
    input logic             ld_retire,
    input logic             st_commit,
    input logic [1:0]       adm_status,
    input logic             lq_full,
    input logic             sq_full,
    input logic [CNT_W-1:0] lq_used,
    input logic [CNT_W-1:0] sq_used
);
    // R3
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adm_status != 2'd3);

    // R4
    no_mem_admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsp_rd && !dsp_wr) |-> adm_status == 2'd0);

    // R2
    lq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LQ_CAP == 0) || (int'(lq_used) <= LQ_CAP));

    // R2
    sq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SQ_CAP == 0) || (int'(sq_used) <= SQ_CAP));

    // R10
    refused_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && adm_status != 2'd0 && !ld_retire) |=> $stable(lq_used));

    // R10
    refused_st_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && adm_status != 2'd0 && !st_commit) |=> $stable(sq_used));

    // R8
    ld_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_rd && adm_status == 2'd0 && ld_retire) |=> $stable(lq_used));

    // R9
    ld_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_retire && !dsp_valid && lq_used == '0) |=> lq_used == '0);

    // R1
    unbounded_lq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LQ_CAP == 0) |-> !lq_full);
endmodule

bind lsq_occupancy lsq_occupancy_chk #(
    .LQ_CAP(LQ_CAP), .SQ_CAP(SQ_CAP), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid), .dsp_rd(dsp_rd),
    .dsp_wr(dsp_wr), .ld_retire(ld_retire), .st_commit(st_commit),
    .adm_status(adm_status), .lq_full(lq_full), .sq_full(sq_full),
    .lq_used(lq_used), .sq_used(sq_used)
);

// File: tb/lsq_occupancy_bench.sv
`timescale 1ns/1ps
module lsq_occupancy_bench;
    localparam int LQC = 4;
    localparam int SQC = 3;
    localparam int CW  = 6;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dsp_valid = 1'b0, dsp_rd = 1'b0, dsp_wr = 1'b0;
    logic ld_retire = 1'b0, st_commit = 1'b0;

    logic [1:0]    st_a, st_b;
    logic          lqe_a, lqf_a, sqe_a, sqf_a, lqu_a, squ_a;
    logic          lqe_b, lqf_b, sqe_b, sqf_b, lqu_b, squ_b;
    logic [CW-1:0] lq_a, sq_a, lq_b, sq_b;

    int n_chk = 0;
    int n_fail = 0;
    int ml_a = 0, ms_a = 0, ml_b = 0, ms_b = 0;

    always #4 clk = ~clk;

    lsq_occupancy #(.LQ_CAP(LQC), .SQ_CAP(SQC), .CNT_W(CW)) u_lsq_occupancy (
        .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid), .dsp_rd(dsp_rd),
        .dsp_wr(dsp_wr), .ld_retire(ld_retire), .st_commit(st_commit),
        .adm_status(st_a), .lq_empty(lqe_a), .lq_full(lqf_a), .sq_empty(sqe_a),
        .sq_full(sqf_a), .lq_used(lq_a), .sq_used(sq_a),
        .lq_underflow(lqu_a), .sq_underflow(squ_a)
    );

    lsq_occupancy #(.LQ_CAP(0), .SQ_CAP(SQC), .CNT_W(CW)) u_lsq_occupancy_unb (
        .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid), .dsp_rd(dsp_rd),
        .dsp_wr(dsp_wr), .ld_retire(ld_retire), .st_commit(st_commit),
        .adm_status(st_b), .lq_empty(lqe_b), .lq_full(lqf_b), .sq_empty(sqe_b),
        .sq_full(sqf_b), .lq_used(lq_b), .sq_used(sq_b),
        .lq_underflow(lqu_b), .sq_underflow(squ_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_full(input int cap, input int u);
        return (cap != 0) && (u == cap);
    endfunction

    function automatic int m_status(input int cl, input int cs, input int ul,
                                    input int us, input bit rd, input bit wr);
        if (rd && m_full(cl, ul)) return 1;
        if (wr && m_full(cs, us)) return 2;
        return 0;
    endfunction

    function automatic int m_next(input int u, input bit al, input bit rl);
        if (al && !rl && u != MAXC) return u + 1;
        if (rl && !al && u != 0)    return u - 1;
        return u;
    endfunction

    // Checks the registered outputs of both instances against the model.
    task automatic check_state();
        chk(int'(lq_a) == ml_a, "R5/R7 lq_used", int'(lq_a), ml_a);
        chk(int'(sq_a) == ms_a, "R5/R7 sq_used", int'(sq_a), ms_a);
        chk(lqf_a == m_full(LQC, ml_a), "R2 lq_full", lqf_a, m_full(LQC, ml_a));
        chk(sqf_a == m_full(SQC, ms_a), "R2 sq_full", sqf_a, m_full(SQC, ms_a));
        chk(lqe_a == (ml_a == 0), "R2 lq_empty", lqe_a, ml_a == 0);
        chk(sqe_a == (ms_a == 0), "R2 sq_empty", sqe_a, ms_a == 0);
        chk(int'(lq_b) == ml_b, "R1/R11 unbounded lq_used", int'(lq_b), ml_b);
        chk(int'(sq_b) == ms_b, "R5 unbounded-inst sq_used", int'(sq_b), ms_b);
        chk(lqf_b == 1'b0, "R1 unbounded lq_full", lqf_b, 0);
    endtask

    // Drives one cycle of stimulus, checks combinational answers, advances the model.
    task automatic step(input bit v, input bit rd, input bit wr, input bit lr, input bit sc);
        int ea, eb;
        bit aa, ab;
        @(negedge clk);
        check_state();
        dsp_valid = v; dsp_rd = rd; dsp_wr = wr; ld_retire = lr; st_commit = sc;
        #1;
        ea = m_status(LQC, SQC, ml_a, ms_a, rd, wr);
        eb = m_status(0, SQC, ml_b, ms_b, rd, wr);
        chk(int'(st_a) == ea, "R3/R4/R6 status", int'(st_a), ea);
        chk(int'(st_b) == eb, "R1/R3 unbounded status", int'(st_b), eb);
        chk(lqu_a == (lr && ml_a == 0), "R9 lq_underflow", lqu_a, lr && ml_a == 0);
        chk(squ_a == (sc && ms_a == 0), "R9 sq_underflow", squ_a, sc && ms_a == 0);
        aa = v && (ea == 0);
        ab = v && (eb == 0);
        ml_a = m_next(ml_a, aa && rd, lr);
        ms_a = m_next(ms_a, aa && wr, sc);
        ml_b = m_next(ml_b, ab && rd, lr);
        ms_b = m_next(ms_b, ab && wr, sc);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R2)
        step(0, 0, 0, 0, 0);
        // R9: release at zero
        step(0, 0, 0, 1, 1);
        // R5: fill the load queue with loads or load barriers, then refuse (R10)
        for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0);
        // R4: request with no memory flags is admitted while the load queue is full
        step(1, 0, 0, 0, 0);
        // R8: admit store together with its commit
        step(1, 0, 1, 0, 1);
        // Fill the store queue; R6: both queues full gives 1, only store full gives 2
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0);
        step(1, 1, 1, 0, 0);
        step(1, 0, 0, 1, 0);
        step(1, 1, 1, 0, 0);
        // R7: drain both queues, including an extra release (R9)
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            bit v, rd, wr, lr, sc;
            v  = ($urandom % 4) != 0;
            rd = ($urandom % 2) != 0;
            wr = ($urandom % 3) == 0;
            lr = ($urandom % 3) == 0;
            sc = ($urandom % 3) == 0;
            step(v, rd, wr, lr, sc);
        end
        // R11: drive the unbounded load queue into saturation
        for (int i = 0; i < MAXC + 10; i++) step(1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(int'(lq_b) == MAXC, "R11 saturation", int'(lq_b), MAXC);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule